// File: doc/BRIEF.md
# Two-Wire Slave Output Port Controller

The block is a two-wire (I2C) slave that owns an eight-bit output register and reports the real pin levels when it is read. It oversamples the bus clock and data lines with the system clock, rejects short pulses on both, detects START and STOP, and takes in an address byte. Three upper address bits are fixed by parameter. The lower four come from an input that is compared on every transaction, so the address can change at run time.

There is no register pointer. After a matching write address, each data byte is acknowledged and replaces the whole output register. After a matching read address, the pin levels are captured during the acknowledge clock and shifted out. Each master acknowledge captures the pins again for the next byte.

A power-on reset loads a supplied pattern into the output register. A separate active-low bus reset drops any transaction in progress and leaves the output register alone.

Top module: `i2c_oport`

## Requirements
- R1: While rst_ni is low, the output register takes the value of pwrup_i and sda_pull_o is low.
- R2: The slave address is {ADDR_HI, addr_lo_i}, sent MSB first and followed by a direction bit (0 = write, 1 = read). A match is acknowledged by holding sda_pull_o high through the ninth clock. sda_pull_o only goes high while the filtered SCL is low.
- R3: During a write, every data byte is acknowledged and replaces all eight bits of port_o at the falling SCL edge after its eighth bit. This repeats for any number of bytes up to STOP. Outside such an update, port_o holds its value.
- R4: When the address does not match, nothing is acknowledged and port_o does not change. The slave then ignores the bus until the next START or STOP.
- R5: A matching read captures pins_i at the rising SCL edge of the address acknowledge and sends that value MSB first. Data comes from pins_i and never from port_o.
- R6: When the master acknowledges a read byte, pins_i is captured again at that acknowledge clock and the new value is sent as the next byte.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until START or STOP.
- R8: A repeated START in any state restarts address reception without a STOP.
- R9: While bus_rst_ni is low, sda_pull_o is low and the transaction is abandoned. port_o is not changed, and the slave waits for a new START.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_CYC clock cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| bus_rst_ni | input | 1 | Bus abort reset, active low, asynchronous |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_pull_o | output | 1 | High to pull SDA low |
| addr_lo_i | input | 4 | Lower address bits |
| pwrup_i | input | 8 | Output value loaded at power-on reset |
| port_o | output | 8 | Output register |
| pins_i | input | 8 | Actual pin levels for readback |

## Verification
The bench sets pins_i to values different from port_o. A design that returned the latch contents would therefore read back the wrong byte. Between two read bytes it changes pins_i just before the master acknowledge, which catches any design that captures the pins only once per transaction.

It also covers the following cases:
- A master NACK followed by more clocks, to catch a slave that keeps driving.
- A mismatched address followed by data, to catch a slave that goes on writing.
- A bus reset in the middle of a byte, to catch a slave that acknowledges a half-shifted byte or clears the outputs.
- Short pulses on SCL and SDA inside a byte, which corrupt the data or fake a START or STOP on a design with a weak filter.

// File: rtl/i2c_oport_pkg.sv
package i2c_oport_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_DATA,
    ST_WR_ACK, ST_RD_DATA, ST_RD_ACK, ST_WAIT
  } slv_state_e;
endpackage

// File: rtl/i2c_oport_filter.sv
module i2c_oport_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flt_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  logic s1_q, s2_q, flt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      flt_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q == flt_q) cnt_q <= '0;
      else if (cnt_q == CW'(FILT_CYC - 1)) begin
        flt_q <= s2_q;
        cnt_q <= '0;
      end else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flt_o = flt_q;

  // R10: output follows only a level already seen by the synchronizer
  a_r10_follow_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flt_q) |-> flt_q == $past(s2_q));
endmodule

// File: rtl/i2c_oport_edges.sv
module i2c_oport_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_oport_fsm.sv
module i2c_oport_fsm
  import i2c_oport_pkg::*;
#(
  parameter int         ADDR_LO_W = 4,
  parameter logic [6-ADDR_LO_W:0] ADDR_HI = 3'b101
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 scl_rise_i,
  input  logic                 scl_fall_i,
  input  logic [ADDR_LO_W-1:0] addr_lo_i,
  input  logic [BYTE_W-1:0]    pins_i,
  output logic                 sda_pull_o,
  output logic                 wr_en_o,
  output logic [BYTE_W-1:0]    wr_data_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  slv_state_e        state_q;
  logic [BYTE_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rw_q, mack_q, pull_q, wr_en_q;
  logic              match;

  assign match = sr_q[BYTE_W-1:1] == {ADDR_HI, addr_lo_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sr_q    <= '0;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
      wr_en_q <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR_DATA: begin
            if (scl_rise_i) begin
              sr_q  <= {sr_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_W'(BYTE_W)) begin
              if (state_q == ST_WR_DATA) begin
                pull_q  <= 1'b1;
                wr_en_q <= 1'b1;
                state_q <= ST_WR_ACK;
              end else if (match) begin
                pull_q  <= 1'b1;
                rw_q    <= sr_q[0];
                state_q <= ST_ADDR_ACK;
              end else state_q <= ST_WAIT;
            end
          end
          ST_ADDR_ACK: begin
            if (scl_rise_i && rw_q) sr_q <= pins_i;
            else if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                pull_q  <= ~sr_q[BYTE_W-1];
                state_q <= ST_RD_DATA;
              end else begin
                pull_q  <= 1'b0;
                state_q <= ST_WR_DATA;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              pull_q  <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_WR_DATA;
            end
          end
          ST_RD_DATA: begin
            if (scl_fall_i) begin
              if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                pull_q  <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                sr_q   <= {sr_q[BYTE_W-2:0], 1'b0};
                pull_q <= ~sr_q[BYTE_W-2];
                cnt_q  <= cnt_q + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
              if (!sda_i) sr_q <= pins_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                cnt_q   <= '0;
                pull_q  <= ~sr_q[BYTE_W-1];
                state_q <= ST_RD_DATA;
              end else state_q <= ST_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_en_o    = wr_en_q;
  assign wr_data_o  = sr_q;

  // R2: SDA is only taken while the clock is low
  a_r2_pull_on_low_scl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_q) |-> !scl_i);
  // R7: a slave that has let go stays silent
  a_r7_wait_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |-> !pull_q);
endmodule

// File: rtl/i2c_oport.sv
module i2c_oport
  import i2c_oport_pkg::*;
#(
  parameter int FILT_CYC  = 3,
  parameter int ADDR_LO_W = 4,
  parameter logic [6-ADDR_LO_W:0] ADDR_HI = 3'b101
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_pull_o,
  input  logic [ADDR_LO_W-1:0] addr_lo_i,
  input  logic [BYTE_W-1:0]    pwrup_i,
  output logic [BYTE_W-1:0]    port_o,
  input  logic [BYTE_W-1:0]    pins_i
);
  logic [1:0] raw, flt;
  logic scl_f, sda_f, start, stop, scl_rise, scl_fall;
  logic wr_en, fsm_rst_n;
  logic [BYTE_W-1:0] wr_data, port_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_oport_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk_i (clk_i), .rst_ni(rst_ni), .raw_i(raw[g]), .flt_o(flt[g]));
  end
  assign scl_f = flt[1];
  assign sda_f = flt[0];

  i2c_oport_edges u_edges (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_f), .sda_i(sda_f),
    .start_o(start), .stop_o(stop), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall));

  assign fsm_rst_n = rst_ni & bus_rst_ni;

  i2c_oport_fsm #(.ADDR_LO_W(ADDR_LO_W), .ADDR_HI(ADDR_HI)) u_fsm (
    .clk_i(clk_i), .rst_ni(fsm_rst_n), .scl_i(scl_f), .sda_i(sda_f),
    .start_i(start), .stop_i(stop), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .addr_lo_i(addr_lo_i), .pins_i(pins_i), .sda_pull_o(sda_pull_o),
    .wr_en_o(wr_en), .wr_data_o(wr_data));

  // output register: only power-on reset clears it, bus reset does not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) port_q <= pwrup_i;
    else if (wr_en) port_q <= wr_data;
  end
  assign port_o = port_q;

  // R3: port changes only through a write strobe
  a_r3_port_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(port_q));
  // R9: bus reset releases SDA
  a_r9_abort_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rst_ni |-> !sda_pull_o);
endmodule

// File: tb/i2c_oport_tb.sv
module i2c_oport_tb;
  localparam int Q = 8;
  logic clk = 1'b0;
  logic rst_ni = 1'b0, bus_rst_ni = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] addr_lo = 4'hA;
  logic [7:0] pwrup = 8'hF0, pins = 8'h00;
  logic sda_pull;
  logic [7:0] port;
  logic sda_line;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  i2c_oport u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_rst_ni(bus_rst_ni), .scl_i(scl_m),
    .sda_i(sda_line), .sda_pull_o(sda_pull), .addr_lo_i(addr_lo),
    .pwrup_i(pwrup), .port_o(port), .pins_i(pins));

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  // one clock with master driving b; returns line level mid-high
  task automatic bit_clk(input bit b, input bit glitch, output bit seen);
    sda_m = b; w(Q/2);
    if (glitch) begin scl_m = 1'b1; w(2); scl_m = 1'b0; w(Q/2 - 2); end
    else w(Q/2);
    scl_m = 1'b1; w(Q/2);
    if (glitch) begin sda_m = ~b; w(2); sda_m = b; w(Q/2 - 2); end
    else w(Q/2);
    seen = sda_line; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], glitch, s);
    bit_clk(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic recv_bits(output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin bit_clk(1'b1, 1'b0, s); d[i] = s; end
  endtask

  task automatic t_reset();
    chk(port == 8'hF0, "R1 reset port", port, 8'hF0);
    chk(sda_pull == 1'b0, "R1 reset pull", {7'b0, sda_pull}, 8'h00);
  endtask

  task automatic t_write();
    bit a;
    i2c_start();
    send_byte(8'hB4, 0, a); chk(a, "R2 addr ack", {7'b0, a}, 8'h01);
    send_byte(8'h3C, 0, a); chk(a, "R3 data ack", {7'b0, a}, 8'h01);
    chk(port == 8'h3C, "R3 first byte", port, 8'h3C);
    send_byte(8'hC3, 0, a);
    chk(port == 8'hC3, "R3 second byte", port, 8'hC3);
    i2c_stop();
    chk(port == 8'hC3, "R3 hold after stop", port, 8'hC3);
  endtask

  task automatic t_mismatch();
    bit a;
    i2c_start();
    send_byte(8'hB6, 0, a); chk(!a, "R4 no ack", {7'b0, a}, 8'h00);
    send_byte(8'h11, 0, a); chk(!a, "R4 data no ack", {7'b0, a}, 8'h00);
    chk(port == 8'hC3, "R4 port kept", port, 8'hC3);
    i2c_stop();
  endtask

  task automatic t_read();
    bit a;
    logic [7:0] d;
    pins = 8'h5A;
    i2c_start();
    send_byte(8'hB5, 0, a); chk(a, "R2 read addr ack", {7'b0, a}, 8'h01);
    recv_bits(d); chk(d == 8'h5A, "R5 pin readback", d, 8'h5A);
    pins = 8'h96;
    bit_clk(1'b0, 0, a);
    recv_bits(d); chk(d == 8'h96, "R6 resampled", d, 8'h96);
    bit_clk(1'b1, 0, a);
    pins = 8'h00;
    recv_bits(d); chk(d == 8'hFF, "R7 released after nack", d, 8'hFF);
    i2c_stop();
  endtask

  task automatic t_restart();
    bit a;
    logic [7:0] d;
    pins = 8'h81;
    i2c_start();
    send_byte(8'hB4, 0, a);
    send_byte(8'h24, 0, a);
    i2c_start();
    send_byte(8'hB5, 0, a); chk(a, "R8 restart ack", {7'b0, a}, 8'h01);
    recv_bits(d); chk(d == 8'h81, "R8 restart read", d, 8'h81);
    bit_clk(1'b1, 0, a);
    i2c_stop();
    chk(port == 8'h24, "R8 write before restart", port, 8'h24);
  endtask

  task automatic t_bus_reset();
    bit a, s;
    i2c_start();
    send_byte(8'hB4, 0, a);
    for (int i = 0; i < 4; i++) bit_clk(1'b0, 0, s);
    bus_rst_ni = 1'b0; w(2);
    chk(sda_pull == 1'b0, "R9 pull released", {7'b0, sda_pull}, 8'h00);
    w(3); bus_rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) bit_clk(1'b0, 0, s);
    bit_clk(1'b1, 0, s);
    chk(s == 1'b1, "R9 no ack after abort", {7'b0, s}, 8'h01);
    chk(port == 8'h24, "R9 port kept", port, 8'h24);
    i2c_stop();
    i2c_start();
    send_byte(8'hB4, 0, a); chk(a, "R9 recovers", {7'b0, a}, 8'h01);
    i2c_stop();
  endtask

  task automatic t_glitch();
    bit a;
    i2c_start();
    send_byte(8'hB4, 0, a);
    send_byte(8'hA5, 1, a); chk(a, "R10 ack with glitches", {7'b0, a}, 8'h01);
    chk(port == 8'hA5, "R10 data intact", port, 8'hA5);
    i2c_stop();
  endtask

  task automatic t_dyn_addr();
    bit a;
    addr_lo = 4'h7; w(Q);
    i2c_start();
    send_byte(8'hB4, 0, a); chk(!a, "R4 old addr ignored", {7'b0, a}, 8'h00);
    i2c_stop();
    i2c_start();
    send_byte(8'hAE, 0, a); chk(a, "R2 new addr ack", {7'b0, a}, 8'h01);
    send_byte(8'h69, 0, a);
    chk(port == 8'h69, "R3 write new addr", port, 8'h69);
    i2c_stop();
  endtask

  initial begin
    w(4);
    t_reset();
    rst_ni = 1'b1; w(Q);
    t_reset();
    t_write();
    t_mismatch();
    t_read();
    t_restart();
    t_bus_reset();
    t_glitch();
    t_dyn_addr();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule